// File: doc/BRIEF.md
# Partitioned Multi-Operand Add Tree

The block adds a fixed number of 16-bit operands (0 to 15, set at build time) into one 16-bit result. Two run-time split controls can cut the result word at bit 4 and at bit 8. Each piece of the word is then an independent lane. A lane wraps within its own bits, and no carry crosses an active split. With both splits off the block is a plain modulo-2^16 multi-operand adder. With splits on, it sums several narrower vectors at once.

Inside, a tree of carry-save levels reduces the operands. Each level turns every group of three operands into two. A level also blocks any carry that would cross an active split. When two operands remain, a split-aware carry-propagate adder forms the result. A build-time bit mask chooses which tree levels end in a pipeline register, and each selected level adds one clock of latency. Mask bits that name a level deeper than the tree for the chosen operand count are ignored. The split controls are carried down the pipeline beside the data, so the mode may change on every clock.

Top module: `lane_sum_tree`

## Requirements
- R1: With zero operands configured, `sum_o` is 0 in every cycle.
- R2: With `split4_i`=0 and `split8_i`=0, `sum_o` is the sum of all operands modulo 2^16.
- R3: With `split4_i`=0 and `split8_i`=1, `sum_o[15:8]` and `sum_o[7:0]` are two independent lane sums. Each is the sum of the matching operand bits modulo 2^8.
- R4: With `split4_i`=1 and `split8_i`=0, `sum_o[15:4]` is the modulo-2^12 sum of the operand bits 15:4, and `sum_o[3:0]` is the modulo-2^4 sum of the operand bits 3:0.
- R5: With both splits set, `sum_o[15:8]`, `sum_o[7:4]` and `sum_o[3:0]` are three independent lane sums, each wrapping within its own bits.
- R6: Each carry-save level maps a count of c operands to 2*floor(c/3)+(c mod 3), until two remain. Level indices 0..L-1 are the carry-save levels and index L is the final adder. Latency in clocks equals the number of set bits of `REG_LEVELS` at indices 0..L. A new operand set is accepted every clock. Example: 9 operands give L=4, and the mask 0x0015 gives 3 clocks.
- R7: Bits of `REG_LEVELS` above index L have no effect on latency or on the result. For example, bit 9 with 9 operands, or bit 1 with 0 operands (where L=0), is ignored.
- R8: The split controls are taken in the same cycle as the operands and travel with them, so each result uses the mode of its own operand set, even when the mode changes every clock.
- R9: While `rst_ni` is low and at least one level is registered, `sum_o` is 0. Release of `rst_ni` takes effect through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| split4_i | input | 1 | Cut the result lanes at bit 4 |
| split8_i | input | 1 | Cut the result lanes at bit 8 |
| ops_i | input | max(N_OPS,1)*W | Operands; operand i sits at bits [i*W +: W] |
| sum_o | output | W | Lane-wise sum |

## Verification
The bench builds three copies of the block, and all of them share the same stimulus. The first copy uses 9 operands, giving four carry-save levels. Its mask selects levels 0, 2 and the final adder, plus an out-of-range bit 9. This copy covers the pipelined latency, the ignored deep level, and mode changes on every clock. The second copy uses zero operands with levels 0 and 1 selected, which exercises the empty sum and the rule that an out-of-range level is ignored even when the tree is empty. The third copy uses 3 operands and no registers, so the same lane rules are checked on a purely combinational single-level tree.

// File: rtl/lst_pkg.sv
`timescale 1ns/1ps
package lst_pkg;

  // operand count left after s carry-save levels
  function automatic int ops_after(input int n, input int s);
    int c;
    c = n;
    for (int i = 0; i < s; i++) begin
      if (c > 2) c = 2 * (c / 3) + (c % 3);
    end
    return c;
  endfunction

  // number of carry-save levels needed to reach two operands
  function automatic int csa_levels(input int n);
    int c;
    int k;
    c = n;
    k = 0;
    for (int i = 0; i < 32; i++) begin
      if (c > 2) begin
        c = 2 * (c / 3) + (c % 3);
        k++;
      end
    end
    return k;
  endfunction

  function automatic int count_ones(input logic [15:0] v);
    int k;
    k = 0;
    for (int i = 0; i < 16; i++) k += int'(v[i]);
    return k;
  endfunction

endpackage

// File: rtl/lst_csa_level.sv
`timescale 1ns/1ps
module lst_csa_level #(
  parameter int W     = 16,
  parameter int PA    = 4,
  parameter int PB    = 8,
  parameter int N_IN  = 3,
  parameter bit REG   = 1'b0,
  localparam int NG    = N_IN / 3,
  localparam int NR    = N_IN % 3,
  localparam int N_OUT = 2 * NG + NR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                split4_i,
  input  logic                split8_i,
  input  logic [N_IN*W-1:0]   ops_i,
  output logic                split4_o,
  output logic                split8_o,
  output logic [N_OUT*W-1:0]  ops_o
);

  localparam int SW = N_OUT * W + 2;

  logic [W-1:0]       kill;
  logic [W-1:0]       a, b, c, mj;
  logic [N_OUT*W-1:0] nxt;
  logic [SW-1:0]      state_d, state_q;

  // carry may not enter the first bit of an active lane
  always_comb begin
    kill     = '0;
    kill[PA] = split4_i;
    kill[PB] = split8_i;
  end

  always_comb begin
    nxt = '0;
    a   = '0;
    b   = '0;
    c   = '0;
    mj  = '0;
    for (int g = 0; g < NG; g++) begin
      a  = ops_i[(3*g)*W   +: W];
      b  = ops_i[(3*g+1)*W +: W];
      c  = ops_i[(3*g+2)*W +: W];
      mj = (a & b) | (a & c) | (b & c);
      nxt[(2*g)*W   +: W] = a ^ b ^ c;
      nxt[(2*g+1)*W +: W] = {mj[W-2:0], 1'b0} & ~kill;
    end
    for (int r = 0; r < NR; r++) begin
      nxt[(2*NG+r)*W +: W] = ops_i[(3*NG+r)*W +: W];
    end
  end

  assign state_d = {split4_i, split8_i, nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign {split4_o, split8_o, ops_o} = REG ? state_q : state_d;

endmodule

// File: rtl/lst_cpa.sv
`timescale 1ns/1ps
module lst_cpa #(
  parameter int W   = 16,
  parameter int PA  = 4,
  parameter int PB  = 8,
  parameter bit REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         split4_i,
  input  logic         split8_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] sum_d, sum_q;

  // ripple add; the carry chain restarts at each active split
  always_comb begin
    logic cy;
    cy    = 1'b0;
    sum_d = '0;
    for (int i = 0; i < W; i++) begin
      if ((i == PA && split4_i) || (i == PB && split8_i)) cy = 1'b0;
      sum_d[i] = a_i[i] ^ b_i[i] ^ cy;
      cy       = (a_i[i] & b_i[i]) | (a_i[i] & cy) | (b_i[i] & cy);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  assign sum_o = REG ? sum_q : sum_d;

endmodule

// File: rtl/lane_sum_tree.sv
`timescale 1ns/1ps
module lane_sum_tree
  import lst_pkg::*;
#(
  parameter int          N_OPS      = 9,
  parameter int          W          = 16,
  parameter int          PA         = 4,
  parameter int          PB         = 8,
  parameter logic [15:0] REG_LEVELS = 16'h0015
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                split4_i,
  input  logic                                split8_i,
  input  logic [((N_OPS < 1) ? 1 : N_OPS)*W-1:0] ops_i,
  output logic [W-1:0]                        sum_o
);

  localparam int          NCSA    = csa_levels(N_OPS);
  localparam logic [15:0] LEGAL   = 16'((32'd1 << (NCSA + 1)) - 32'd1);
  localparam logic [15:0] REG_EFF = REG_LEVELS & LEGAL;
  localparam int          LAT     = count_ones(REG_EFF);

  // reset synchroniser: assert at once, release on the clock
  logic [1:0] rs_d, rs_q;
  logic       rst_sync_n;

  assign rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[1];

  // carry-save levels
  for (genvar s = 0; s < NCSA; s++) begin : g_lvl
    localparam int CIN  = ops_after(N_OPS, s);
    localparam int COUT = ops_after(N_OPS, s + 1);

    logic [CIN*W-1:0]  din;
    logic              din_p4, din_p8;
    logic [COUT*W-1:0] dout;
    logic              p4_q, p8_q;

    if (s == 0) begin : g_head
      assign din    = ops_i[CIN*W-1:0];
      assign din_p4 = split4_i;
      assign din_p8 = split8_i;
    end else begin : g_link
      assign din    = g_lvl[s-1].dout;
      assign din_p4 = g_lvl[s-1].p4_q;
      assign din_p8 = g_lvl[s-1].p8_q;
    end

    lst_csa_level #(
      .W(W), .PA(PA), .PB(PB), .N_IN(CIN), .REG(REG_EFF[s])
    ) u_lvl (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .split4_i(din_p4),
      .split8_i(din_p8),
      .ops_i   (din),
      .split4_o(p4_q),
      .split8_o(p8_q),
      .ops_o   (dout)
    );
  end

  // two operands into the final adder
  logic [W-1:0] fin_a, fin_b;
  logic         fin_p4, fin_p8;

  if (NCSA > 0) begin : g_fin_tree
    assign fin_a  = g_lvl[NCSA-1].dout[W-1:0];
    assign fin_b  = g_lvl[NCSA-1].dout[2*W-1:W];
    assign fin_p4 = g_lvl[NCSA-1].p4_q;
    assign fin_p8 = g_lvl[NCSA-1].p8_q;
  end else if (N_OPS == 2) begin : g_fin_two
    assign fin_a  = ops_i[W-1:0];
    assign fin_b  = ops_i[2*W-1:W];
    assign fin_p4 = split4_i;
    assign fin_p8 = split8_i;
  end else if (N_OPS == 1) begin : g_fin_one
    assign fin_a  = ops_i[W-1:0];
    assign fin_b  = '0;
    assign fin_p4 = split4_i;
    assign fin_p8 = split8_i;
  end else begin : g_fin_none
    assign fin_a  = '0;
    assign fin_b  = '0;
    assign fin_p4 = split4_i;
    assign fin_p8 = split8_i;
  end

  lst_cpa #(
    .W(W), .PA(PA), .PB(PB), .REG(REG_EFF[NCSA])
  ) u_cpa (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .split4_i(fin_p4),
    .split8_i(fin_p8),
    .a_i     (fin_a),
    .b_i     (fin_b),
    .sum_o   (sum_o)
  );

endmodule

// File: rtl/lst_chk.sv
`timescale 1ns/1ps
module lst_chk #(
  parameter int N_OPS = 9,
  parameter int W     = 16,
  parameter int PA    = 4,
  parameter int PB    = 8,
  parameter int LAT   = 0
) (
  input  logic                                clk_i,
  input  logic                                rst_n,
  input  logic                                split4_i,
  input  logic                                split8_i,
  input  logic [((N_OPS < 1) ? 1 : N_OPS)*W-1:0] ops_i,
  input  logic [W-1:0]                        sum_o
);

  localparam int           DL   = (LAT < 1) ? 1 : LAT;
  localparam logic [W-1:0] M_LO = W'((1 << PA) - 1);
  localparam logic [W-1:0] M_B0 = W'((1 << PB) - 1);
  localparam logic [W-1:0] M_MD = M_B0 & ~M_LO;
  localparam logic [W-1:0] M_HI = ~M_B0;
  localparam logic [W-1:0] M_UP = ~M_LO;

  // independent reference: masked sums per lane
  logic [W-1:0] s_full, s_lo, s_md, s_hi, s_b0, s_up, ref_v;
  always_comb begin
    s_full = '0; s_lo = '0; s_md = '0; s_hi = '0; s_b0 = '0; s_up = '0;
    for (int i = 0; i < N_OPS; i++) begin
      s_full += ops_i[i*W +: W];
      s_lo   += ops_i[i*W +: W] & M_LO;
      s_md   += ops_i[i*W +: W] & M_MD;
      s_hi   += ops_i[i*W +: W] & M_HI;
      s_b0   += ops_i[i*W +: W] & M_B0;
      s_up   += ops_i[i*W +: W] & M_UP;
    end
    case ({split4_i, split8_i})
      2'b00:   ref_v = s_full;
      2'b01:   ref_v = (s_hi & M_HI) | (s_b0 & M_B0);
      2'b10:   ref_v = (s_up & M_UP) | (s_lo & M_LO);
      default: ref_v = (s_hi & M_HI) | (s_md & M_MD) | (s_lo & M_LO);
    endcase
  end

  logic [W+1:0] line_q [0:DL-1];
  logic [W+1:0] tap;
  logic [3:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DL; k++) line_q[k] <= '0;
      warm_q <= '0;
    end else begin
      line_q[0] <= {split4_i, split8_i, ref_v};
      for (int k = 1; k < DL; k++) line_q[k] <= line_q[k-1];
      if (warm_q != 4'(LAT)) warm_q <= warm_q + 4'd1;
    end
  end

  assign tap = (LAT == 0) ? {split4_i, split8_i, ref_v} : line_q[DL-1];

  // R6 R7 R8: each comparison uses the latency and the mode of its own operand set
  AST_FULL_SUM: assert property (@(posedge clk_i) disable iff (!rst_n)
    (warm_q == 4'(LAT) && tap[W+1:W] == 2'b00) |-> sum_o == tap[W-1:0]); // R2
  AST_BYTE_LANES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (warm_q == 4'(LAT) && tap[W+1:W] == 2'b01) |-> sum_o == tap[W-1:0]); // R3
  AST_NIBBLE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (warm_q == 4'(LAT) && tap[W+1:W] == 2'b10) |-> sum_o == tap[W-1:0]); // R4
  AST_THREE_LANES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (warm_q == 4'(LAT) && tap[W+1:W] == 2'b11) |-> sum_o == tap[W-1:0]); // R5

  if (N_OPS == 0) begin : g_empty
    AST_ZERO_OPS: assert property (@(posedge clk_i) disable iff (!rst_n)
      (warm_q == 4'(LAT)) |-> sum_o == '0); // R1
  end

endmodule

bind lane_sum_tree lst_chk #(
  .N_OPS(N_OPS), .W(W), .PA(PA), .PB(PB), .LAT(LAT)
) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .split4_i(split4_i),
  .split8_i(split8_i),
  .ops_i   (ops_i),
  .sum_o   (sum_o)
);

// File: tb/sim_lane_sum_tree.sv
`timescale 1ns/1ps
module sim_lane_sum_tree;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] val;
  } exp_t;

  localparam int LAT0 = 3;  // 9 ops, levels 0,2,4 (bit 9 ignored)
  localparam int LAT1 = 1;  // 0 ops, level 0 (bit 1 ignored)
  localparam int LAT2 = 0;  // 3 ops, no registers

  logic          clk = 1'b0;
  logic          rst_n;
  logic          p4, p8;
  logic [143:0]  ops9;
  logic [15:0]   ops0;
  logic [47:0]   ops3;
  logic [15:0]   sum0, sum1, sum2;

  int checks = 0;
  int errors = 0;

  exp_t q0[$];
  exp_t q1[$];
  exp_t q2[$];

  always #4 clk = ~clk;

  lane_sum_tree #(.N_OPS(9), .REG_LEVELS(16'h0215)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .split4_i(p4), .split8_i(p8),
    .ops_i(ops9), .sum_o(sum0));

  lane_sum_tree #(.N_OPS(0), .REG_LEVELS(16'h0003)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .split4_i(p4), .split8_i(p8),
    .ops_i(ops0), .sum_o(sum1));

  lane_sum_tree #(.N_OPS(3), .REG_LEVELS(16'h0000)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .split4_i(p4), .split8_i(p8),
    .ops_i(ops3), .sum_o(sum2));

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // expected lane sums, built from the lane masks of each mode
  function automatic logic [15:0] lane_ref(input logic [15:0] v [9], input int n,
                                           input logic m4, input logic m8);
    logic [15:0] m [3];
    int          nm;
    logic [15:0] y, acc;
    case ({m4, m8})
      2'b00:   begin m[0] = 16'hFFFF; nm = 1; end
      2'b01:   begin m[0] = 16'hFF00; m[1] = 16'h00FF; nm = 2; end
      2'b10:   begin m[0] = 16'hFFF0; m[1] = 16'h000F; nm = 2; end
      default: begin m[0] = 16'hFF00; m[1] = 16'h00F0; m[2] = 16'h000F; nm = 3; end
    endcase
    y = '0;
    for (int k = 0; k < nm; k++) begin
      acc = '0;
      for (int i = 0; i < n; i++) acc += v[i] & m[k];
      y |= acc & m[k];
    end
    return y;
  endfunction

  task automatic check(input string who, input string tag,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", who, tag, got, exp);
    end
  endtask

  // driver: applies one operand set and its mode, records the expected results
  task automatic drive(input logic [15:0] v [9], input logic m4, input logic m8);
    @(negedge clk);
    p4 = m4;
    p8 = m8;
    for (int i = 0; i < 9; i++) ops9[i*16 +: 16] = v[i];
    for (int i = 0; i < 3; i++) ops3[i*16 +: 16] = v[i];
    ops0 = v[0];
    q0.push_back('{mode: {m4, m8}, val: lane_ref(v, 9, m4, m8)});
    q1.push_back('{mode: {m4, m8}, val: 16'h0000});
    q2.push_back('{mode: {m4, m8}, val: lane_ref(v, 3, m4, m8)});
  endtask

  // monitor: pops an expected item once it has aged by the configured latency
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (q0.size() > LAT0) begin
      e = q0.pop_front();
      check("u0", {mode_tag(e.mode), " R6 R7 R8"}, sum0, e.val);
    end
    if (q1.size() > LAT1) begin
      e = q1.pop_front();
      check("u1", "R1 R7", sum1, e.val);
    end
    if (q2.size() > LAT2) begin
      e = q2.pop_front();
      check("u2", {mode_tag(e.mode), " R8"}, sum2, e.val);
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog R6: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v [9];
    rst_n = 1'b0;
    p4    = 1'b1;
    p8    = 1'b0;
    ops9  = {9{16'hA5C3}};
    ops3  = {3{16'hA5C3}};
    ops0  = 16'h1234;
    repeat (3) @(negedge clk);
    #1;
    check("u0", "R9 reset", sum0, 16'h0000);
    check("u1", "R9 reset", sum1, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // all zero in every mode
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 9; i++) v[i] = 16'h0000;
      drive(v, md[1], md[0]);
    end
    // every operand all ones: each lane wraps on its own
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 9; i++) v[i] = 16'hFFFF;
      drive(v, md[1], md[0]);
    end
    // carries that reach exactly bit 4 and bit 8
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 9; i++) v[i] = (i % 2 == 0) ? 16'h00FF : 16'h0F0F;
      drive(v, md[1], md[0]);
    end
    // single nonzero operand in varying position
    for (int k = 0; k < 9; k++) begin
      for (int i = 0; i < 9; i++) v[i] = (i == k) ? 16'h8421 << (k % 4) : 16'h0000;
      drive(v, k[0], k[1]);
    end
    // random operands with a new mode every clock
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 9; i++) v[i] = 16'($urandom);
      drive(v, 1'($urandom), 1'($urandom));
    end
    // drain
    for (int n = 0; n < 5; n++) begin
      for (int i = 0; i < 9; i++) v[i] = 16'h0000;
      drive(v, 1'b0, 1'b0);
    end
    @(negedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule